// File: doc/BRIEF.md
# Page Table Entry Cache with Physical Tags

This block holds a small set of upper-level page table entries for a page walker. Each entry is identified by where it lives in memory: the physical page number of the table page that contains it, plus the 9-bit slot index inside that page. Its payload is the physical page number of the next table page down. At every walk step the walker presents the current table page number and the index taken from the virtual address. On a hit the walker gets the next page number one cycle later and makes no memory access. On a miss it reads memory and then writes the result into the cache through the fill port.

Entries from the three upper levels share one fully associative store of 24 slots. Leaf-level entries are never offered to it. The walker follows the chain from the root register, so each lookup depends on the result of the one before it. When all three upper steps hit, a walk costs a single memory read. The store is read-only with respect to memory. Software keeps it consistent by pulsing the flush input, which clears every valid bit in one cycle.

The lookup response is produced by a three-state machine. `RSP_NONE` means no lookup was presented in the previous cycle. `RSP_HIT` means the previous lookup matched. `RSP_MISS` means it did not match. The next state is chosen every cycle from the lookup request and the match result: NONE→HIT, NONE→MISS, HIT→MISS and the others are all direct transitions, and any state returns to `RSP_NONE` when no lookup is presented.

Top module: `ptw_entry_cache`

## Requirements
- R1: After reset no slot is valid: `rsp_valid` is low, and a lookup of any address answers with `rsp_hit` low.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and `rsp_hit` is never high without `rsp_valid`.
- R3: A lookup hits only when both the 40-bit page number and the 9-bit index equal a stored tag. A difference in either field gives a miss.
- R4: A fill followed by a lookup of the same tag in a later cycle hits, and `rsp_next` carries the filled next-page number.
- R5: A fill whose tag is already stored overwrites that slot's payload and does not take a second slot.
- R6: 24 fills of distinct tags into an empty cache all remain resident and all hit afterwards.
- R7: When all slots are valid, a fill of a new tag replaces the least recently used slot. Both a lookup hit and a fill count as a use. Empty slots are always taken before anything is evicted.
- R8: A lookup and a fill may occur in the same cycle. The lookup sees the contents from before the fill, so a lookup of the tag being filled misses, and a lookup of it in the next cycle hits.
- R9: A flush invalidates every slot in one cycle. A lookup in the flush cycle misses, and a fill in the flush cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | 40 | Table page number of the entry being looked up |
| lk_index | input | 9 | Slot index within that table page |
| fill_valid | input | 1 | Fill request |
| fill_page | input | 40 | Table page number of the entry being filled |
| fill_index | input | 9 | Slot index of the entry being filled |
| fill_next | input | 40 | Next-level page number to store |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup response is a hit |
| rsp_next | output | 40 | Next-level page number on a hit, zero otherwise |

## Verification
A lookup and a fill can land in the same cycle, and so can a lookup and a flush. The bench drives a fill and a lookup of the same new tag on one edge. It expects a miss from that edge and a hit with the filled payload one lookup later, which shows that the fill was not forwarded. It also pulses flush together with a lookup of a resident tag and a fill of a new tag. It expects the lookup to miss, and it expects both the old tag and the new tag to miss afterwards.

// File: rtl/pec_pkg.sv
package pec_pkg;
    parameter int PEC_PPN_W   = 40;
    parameter int PEC_IDX_W   = 9;
    parameter int PEC_ENTRIES = 24;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_t;
endpackage

// File: rtl/pec_store.sv
module pec_store #(
    parameter int ENTRIES = 24,
    parameter int PPN_W   = 40,
    parameter int IDX_W   = 9,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [PPN_W-1:0]   lk_page,
    input  logic [IDX_W-1:0]   lk_index,
    input  logic [PPN_W-1:0]   fill_page,
    input  logic [IDX_W-1:0]   fill_index,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [PPN_W-1:0]   wr_next,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] fill_match,
    output logic [PPN_W-1:0]   lk_next,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [PPN_W-1:0] tag_page [ENTRIES];
    logic [IDX_W-1:0] tag_idx  [ENTRIES];
    logic [PPN_W-1:0] payload  [ENTRIES];

    // flush wins over a write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_vec <= '0;
        end else if (wr_en) begin
            valid_vec[wr_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_page[wr_slot] <= fill_page;
            tag_idx[wr_slot]  <= fill_index;
            payload[wr_slot]  <= wr_next;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = valid_vec[g] && (tag_page[g] == lk_page)
                               && (tag_idx[g] == lk_index);
        assign fill_match[g] = valid_vec[g] && (tag_page[g] == fill_page)
                               && (tag_idx[g] == fill_index);
    end

    always_comb begin
        lk_next = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_next = lk_next | payload[i];
        end
    end
endmodule

// File: rtl/pec_lru.sv
module pec_lru #(
    parameter int ENTRIES = 24,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [SLOT_W-1:0]  touch_slot,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [SLOT_W-1:0]  victim
);
    logic [SLOT_W-1:0] age [ENTRIES];
    logic [SLOT_W-1:0] touched_age;

    assign touched_age = age[touch_slot];

    // ages stay a permutation of 0..ENTRIES-1; 0 is the newest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age[i] <= SLOT_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (SLOT_W'(i) == touch_slot)  age[i] <= '0;
                else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_vec[i]) begin
                victim = SLOT_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age[i] == SLOT_W'(ENTRIES - 1)) victim = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ptw_entry_cache.sv
module ptw_entry_cache
    import pec_pkg::*;
#(
    parameter int ENTRIES = PEC_ENTRIES,
    parameter int PPN_W   = PEC_PPN_W,
    parameter int IDX_W   = PEC_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PPN_W-1:0] lk_page,
    input  logic [IDX_W-1:0] lk_index,
    input  logic             fill_valid,
    input  logic [PPN_W-1:0] fill_page,
    input  logic [IDX_W-1:0] fill_index,
    input  logic [PPN_W-1:0] fill_next,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_next
);
    localparam int SLOT_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] lk_match, fill_match, valid_vec;
    logic [PPN_W-1:0]   lk_next;
    logic [SLOT_W-1:0]  victim, lk_slot, fill_hit_slot, fill_slot;
    logic               lk_hit, fill_hit, wr_en, touch_en;
    logic [SLOT_W-1:0]  touch_slot;
    rsp_state_t         state_q, state_d;
    logic [PPN_W-1:0]   next_q;

    pec_store #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_page(lk_page), .lk_index(lk_index),
        .fill_page(fill_page), .fill_index(fill_index),
        .wr_en(wr_en), .wr_slot(fill_slot), .wr_next(fill_next),
        .lk_match(lk_match), .fill_match(fill_match),
        .lk_next(lk_next), .valid_vec(valid_vec)
    );

    pec_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
        .touch_slot(touch_slot), .valid_vec(valid_vec), .victim(victim)
    );

    always_comb begin
        lk_slot       = '0;
        fill_hit_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i])   lk_slot       = SLOT_W'(i);
            if (fill_match[i]) fill_hit_slot = SLOT_W'(i);
        end
    end

    assign lk_hit    = lk_valid && (|lk_match) && !flush;
    assign fill_hit  = |fill_match;
    assign wr_en     = fill_valid && !flush;
    assign fill_slot = fill_hit ? fill_hit_slot : victim;

    // a fill is the most recent use when both happen together
    assign touch_en   = wr_en || lk_hit;
    assign touch_slot = wr_en ? fill_slot : lk_slot;

    always_comb begin
        unique case (state_q)
            RSP_NONE, RSP_HIT, RSP_MISS: begin
                if (!lk_valid)   state_d = RSP_NONE;
                else if (lk_hit) state_d = RSP_HIT;
                else             state_d = RSP_MISS;
            end
            default: state_d = RSP_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_NONE;
            next_q  <= '0;
        end else begin
            state_q <= state_d;
            next_q  <= lk_hit ? lk_next : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_next  = '0;
        unique case (state_q)
            RSP_NONE: ;
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_next  = next_q;
            end
            RSP_MISS: rsp_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pec_chk.sv
module pec_chk #(
    parameter int ENTRIES = 24,
    parameter int PPN_W   = 40,
    parameter int IDX_W   = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [PPN_W-1:0]   lk_page,
    input logic [IDX_W-1:0]   lk_index,
    input logic               fill_valid,
    input logic [PPN_W-1:0]   fill_page,
    input logic [IDX_W-1:0]   fill_index,
    input logic [PPN_W-1:0]   fill_next,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PPN_W-1:0]   rsp_next,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] fill_match
);
    logic started;
    always_ff @(posedge clk) started <= rst_n;

    // R2
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        lk_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        !lk_valid |=> !rsp_valid);

    // R2
    hit_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R5
    unique_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fill_match));

    // R9
    flush_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (flush && lk_valid) |=> !rsp_hit);

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        flush |=> (lk_match == '0));

    // R4
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (fill_valid && !flush) ##1 (lk_valid && !flush && lk_page == $past(fill_page)
            && lk_index == $past(fill_index)) |=> (rsp_hit && rsp_next == $past(fill_next, 2)));
endmodule

bind ptw_entry_cache pec_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_page(lk_page),
    .lk_index(lk_index), .fill_valid(fill_valid), .fill_page(fill_page),
    .fill_index(fill_index), .fill_next(fill_next), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next(rsp_next),
    .lk_match(lk_match), .fill_match(fill_match)
);

// File: tb/ptw_entry_cache_tb.sv
`timescale 1ns/1ps
module ptw_entry_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, fill_valid = 1'b0, flush = 1'b0;
    logic [39:0] lk_page = '0, fill_page = '0, fill_next = '0;
    logic [8:0]  lk_index = '0, fill_index = '0;
    logic        rsp_valid, rsp_hit;
    logic [39:0] rsp_next;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ptw_entry_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_page(lk_page),
        .lk_index(lk_index), .fill_valid(fill_valid), .fill_page(fill_page),
        .fill_index(fill_index), .fill_next(fill_next), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next(rsp_next)
    );

    function automatic logic [39:0] pg(int i);
        return {8'hA5, 32'(i * 7 + 3)};
    endfunction
    function automatic logic [8:0] ix(int i);
        return 9'(i * 5 + 1);
    endfunction
    function automatic logic [39:0] nx(int i);
        return {8'h3C, 32'(i * 11 + 2)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one lookup; response sampled on the negedge after the capturing edge
    task automatic lookup(logic [39:0] p, logic [8:0] i, output logic hit, output logic [39:0] nxt);
        @(negedge clk);
        lk_valid = 1'b1; lk_page = p; lk_index = i;
        @(negedge clk);
        lk_valid = 1'b0;
        hit = rsp_hit; nxt = rsp_next;
    endtask

    task automatic fill(logic [39:0] p, logic [8:0] i, logic [39:0] n);
        @(negedge clk);
        fill_valid = 1'b1; fill_page = p; fill_index = i; fill_next = n;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic expect_hit(string req, int k, logic [39:0] n);
        logic h; logic [39:0] d;
        lookup(pg(k), ix(k), h, d);
        check(h, req, "hit", 64'(h), 64'(1));
        check(d == n, req, "next page", 64'(d), 64'(n));
    endtask

    task automatic expect_miss(string req, logic [39:0] p, logic [8:0] i);
        logic h; logic [39:0] d;
        lookup(p, i, h, d);
        check(!h, req, "miss", 64'(h), 64'(0));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!rsp_valid, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
        expect_miss("R1", pg(0), ix(0));
    endtask

    task automatic t_timing();
        @(negedge clk);
        check(!rsp_valid, "R2", "idle rsp_valid", 64'(rsp_valid), 64'(0));
        lk_valid = 1'b1; lk_page = pg(3); lk_index = ix(3);
        check(!rsp_valid, "R2", "same-cycle rsp_valid", 64'(rsp_valid), 64'(0));
        @(negedge clk);
        lk_valid = 1'b0;
        check(rsp_valid, "R2", "rsp_valid next cycle", 64'(rsp_valid), 64'(1));
        @(negedge clk);
        check(!rsp_valid, "R2", "rsp_valid drops", 64'(rsp_valid), 64'(0));
    endtask

    task automatic t_basic();
        fill(pg(1), ix(1), nx(1));
        expect_hit("R4", 1, nx(1));
        expect_miss("R3", pg(1) ^ 40'h1, ix(1));
        expect_miss("R3", pg(1), ix(1) ^ 9'h100);
    endtask

    task automatic t_capacity();
        do_flush();
        for (int k = 0; k < 24; k++) fill(pg(k), ix(k), nx(k));
        for (int k = 0; k < 24; k++) expect_hit("R6", k, nx(k));
    endtask

    task automatic t_lru();
        // slot 0 is the oldest use; refresh it, then slot 1 is the oldest
        expect_hit("R7", 0, nx(0));
        fill(pg(100), ix(100), nx(100));
        expect_miss("R7", pg(1), ix(1));
        expect_hit("R7", 0, nx(0));
        expect_hit("R7", 100, nx(100));
        for (int k = 2; k < 24; k++) expect_hit("R7", k, nx(k));
    endtask

    task automatic t_refill();
        do_flush();
        for (int k = 0; k < 23; k++) fill(pg(k), ix(k), nx(k));
        fill(pg(0), ix(0), nx(50));
        fill(pg(23), ix(23), nx(23));
        expect_hit("R5", 0, nx(50));
        for (int k = 1; k < 24; k++) expect_hit("R5", k, nx(k));
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill_valid = 1'b1; fill_page = pg(200); fill_index = ix(200); fill_next = nx(200);
        lk_valid = 1'b1; lk_page = pg(200); lk_index = ix(200);
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        check(rsp_valid && !rsp_hit, "R8", "same-cycle lookup", 64'({rsp_valid, rsp_hit}), 64'(2'b10));
        expect_hit("R8", 200, nx(200));
    endtask

    task automatic t_flush();
        fill(pg(5), ix(5), nx(5));
        @(negedge clk);
        flush = 1'b1;
        lk_valid = 1'b1; lk_page = pg(5); lk_index = ix(5);
        fill_valid = 1'b1; fill_page = pg(300); fill_index = ix(300); fill_next = nx(300);
        @(negedge clk);
        flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
        check(rsp_valid && !rsp_hit, "R9", "lookup in flush cycle", 64'({rsp_valid, rsp_hit}), 64'(2'b10));
        expect_miss("R9", pg(5), ix(5));
        expect_miss("R9", pg(300), ix(300));
        expect_miss("R9", pg(200), ix(200));
    endtask

    initial begin
        t_reset();
        t_timing();
        t_basic();
        t_capacity();
        t_lru();
        t_refill();
        t_same_cycle();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule